// File: doc/BRIEF.md
# SMP Boot Arbitration and Reset Distribution

This block supports booting a multiprocessor system of two slots, each holding an A and a B processor. On a small register bus it offers three services to firmware. A one-shot arbitration flag grants boot mastership to whichever processor reads it first. A read-advanced sequence counter hands out processor numbers in order. An enable register starts a timed, whole-system hard reset when zero is written to it.

Beside the registers, the block combines the board's reset sources into per-processor hard-reset and soft-reset lines and per-slot test-reset lines, all active low. It also combines the processors' halt indications and the slots' checkstop inputs into summary outputs. Reads have side effects, so software that only wants to advance the sequence counter reads it and discards the value.

Processor index i belongs to slot i/2; an even index is that slot's A processor and an odd index is its B processor.

Top module: `smp_boot_ctrl`

## Requirements
- R1: A read of the arbitration register (address 0x81C) returns 0 in bit 0 to the first read after hard reset and 1 to every later read; bits 7:1 read 0.
- R2: A read of the sequence register (address 0x820) returns the 2-bit count in bits 1:0 and then advances it by one, wrapping from 3 to 0.
- R3: Writing 0x00 to the enable register (address 0x871) makes the internal hard reset active from the next cycle for exactly 16 cycles; sys_hrst_n is low while it is active; a nonzero write has no effect.
- R4: While the global hard reset is active (hreset_in_n low or the internal reset running), the arbitration flag and the sequence count are cleared, bus accesses are ignored and bus_rdata reads 0.
- R5: cpu_hrst_n[i] is low exactly when the global hard reset is active or cpu_rst_req_n[i] is low.
- R6: slot_trst_n[s] is low exactly when dbg_ovr_n is low or the request of that slot's A processor, cpu_rst_req_n[2s], is low.
- R7: cpu_srst_n[i] is low exactly when bridge_srst_n is low or port92_rst XOR cpu_init[i] is 1.
- R8: slot_halt[s] is high only when halt_in[2s] and halt_in[2s+1] are both high; all_halted is high only when all four halt_in bits are high.
- R9: cstop_out_n is low only when every bit of slot_cstop_n is low.
- R10: bus_rdata changes only at the clock edge that samples bus_rd and holds the value for that read for one cycle; it is 0 in cycles without a read and for reads of any other address, and such reads have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| hreset_in_n | input | 1 | External global hard reset, active low |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 12 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| sys_hrst_n | output | 1 | Global hard reset for the system, active low |
| cpu_rst_req_n | input | 4 | Per-processor reset requests, active low |
| dbg_ovr_n | input | 1 | Debug override, active low |
| bridge_srst_n | input | 1 | Soft-reset pulse from the bus bridge, active low |
| port92_rst | input | 1 | Port-92 reset bit |
| cpu_init | input | 4 | Per-processor init lines from the interrupt controller |
| halt_in | input | 4 | Per-processor halt indications |
| slot_cstop_n | input | 2 | Per-slot checkstop, active low |
| cpu_hrst_n | output | 4 | Per-processor hard reset, active low |
| cpu_srst_n | output | 4 | Per-processor soft reset, active low |
| slot_trst_n | output | 2 | Per-slot test reset, active low |
| slot_halt | output | 2 | Per-slot both-halted indication |
| all_halted | output | 1 | All processors halted |
| cstop_out_n | output | 1 | Combined checkstop, active low |

## Verification
The bench builds the block with its default parameters: two slots of two processors, a 2-bit sequence counter and a 16-cycle hold. With these values five sequence reads reach the wrap from 3 to 0, and the whole reset window, including its last cycle and its release, fits in a short run. A sweep of mixed reset, init, halt and checkstop patterns then covers every output of the combining logic alongside ongoing bus traffic.

// File: rtl/smp_boot_pkg.sv
package smp_boot_pkg;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_ARB    = 2'd1,
      SEL_SEQ    = 2'd2,
      SEL_ENABLE = 2'd3
   } reg_sel_e;

   localparam int MIN_HOLD_CYCLES = 16;

endpackage

// File: rtl/smp_boot_regs.sv
module smp_boot_regs
   import smp_boot_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 8,
   parameter int SEQ_W      = 2,
   parameter logic [ADDR_W-1:0] ADDR_ARB    = 12'h81C,
   parameter logic [ADDR_W-1:0] ADDR_SEQ    = 12'h820,
   parameter logic [ADDR_W-1:0] ADDR_ENABLE = 12'h871
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              glob_hrst,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              enable_clear_wr
);

   localparam int PAD_ARB = DATA_W - 1;
   localparam int PAD_SEQ = DATA_W - SEQ_W;

   if (SEQ_W < 1 || SEQ_W > DATA_W) begin : g_bad_seq_w
      $error("smp_boot_regs: SEQ_W must lie in 1..DATA_W");
   end
   if (ADDR_ARB == ADDR_SEQ || ADDR_ARB == ADDR_ENABLE || ADDR_SEQ == ADDR_ENABLE) begin : g_bad_map
      $error("smp_boot_regs: register addresses must differ");
   end

   reg_sel_e          sel;
   logic              first_seen;
   logic [SEQ_W-1:0]  seq_cnt;
   logic [DATA_W-1:0] rd_val;
   logic              rd_arb, rd_seq;

   always_comb begin
      if (bus_addr == ADDR_ARB)         sel = SEL_ARB;
      else if (bus_addr == ADDR_SEQ)    sel = SEL_SEQ;
      else if (bus_addr == ADDR_ENABLE) sel = SEL_ENABLE;
      else                              sel = SEL_NONE;
   end

   assign rd_arb = bus_rd && (sel == SEL_ARB);
   assign rd_seq = bus_rd && (sel == SEL_SEQ);
   assign enable_clear_wr = bus_wr && !glob_hrst && (sel == SEL_ENABLE) && (bus_wdata == '0);

   always_comb begin
      rd_val = '0;
      if (bus_rd) begin
         unique case (sel)
            SEL_ARB:    rd_val = {{PAD_ARB{1'b0}}, first_seen};
            SEL_SEQ:    rd_val = {{PAD_SEQ{1'b0}}, seq_cnt};
            SEL_ENABLE: rd_val = '0;
            default:    rd_val = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_seen <= 1'b0;
         seq_cnt    <= '0;
         bus_rdata  <= '0;
      end else if (glob_hrst) begin
         first_seen <= 1'b0;
         seq_cnt    <= '0;
         bus_rdata  <= '0;
      end else begin
         bus_rdata <= rd_val;
         if (rd_arb) first_seen <= 1'b1;
         if (rd_seq) seq_cnt <= seq_cnt + 1'b1;
      end
   end

   a_r1_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_arb && !glob_hrst) |=> first_seen);
   a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_seq && !glob_hrst) |=> (seq_cnt == SEQ_W'($past(seq_cnt) + 1'b1)));
   a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      glob_hrst |=> (!first_seen && seq_cnt == '0 && bus_rdata == '0));
   a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0));

endmodule

// File: rtl/smp_boot_hold.sv
module smp_boot_hold
   import smp_boot_pkg::*;
#(
   parameter int HOLD_CYCLES = 16
)(
   input  logic clk,
   input  logic rst_n,
   input  logic trigger,
   output logic int_hrst
);

   localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
   localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYCLES);

   if (HOLD_CYCLES < MIN_HOLD_CYCLES) begin : g_bad_hold
      $error("smp_boot_hold: HOLD_CYCLES below the minimum hold");
   end

   logic [CNT_W-1:0] hold_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               hold_cnt <= '0;
      else if (hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;
      else if (trigger)         hold_cnt <= HOLD_LOAD;
   end

   assign int_hrst = (hold_cnt != '0);

   a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
      (trigger && !int_hrst) |=> int_hrst);
   a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_hrst) |-> ($past(hold_cnt) == CNT_W'(1)));

endmodule

// File: rtl/smp_boot_fanout.sv
module smp_boot_fanout #(
   parameter int NUM_SLOTS     = 2,
   parameter int CPUS_PER_SLOT = 2
)(
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  glob_hrst,
   input  logic [NUM_SLOTS*CPUS_PER_SLOT-1:0]    cpu_rst_req_n,
   input  logic                                  dbg_ovr_n,
   input  logic                                  bridge_srst_n,
   input  logic                                  port92_rst,
   input  logic [NUM_SLOTS*CPUS_PER_SLOT-1:0]    cpu_init,
   output logic [NUM_SLOTS*CPUS_PER_SLOT-1:0]    cpu_hrst_n,
   output logic [NUM_SLOTS*CPUS_PER_SLOT-1:0]    cpu_srst_n,
   output logic [NUM_SLOTS-1:0]                  slot_trst_n
);

   localparam int NUM_CPUS = NUM_SLOTS * CPUS_PER_SLOT;

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      assign cpu_hrst_n[c] = !(glob_hrst || !cpu_rst_req_n[c]);
      assign cpu_srst_n[c] = !(!bridge_srst_n || (port92_rst ^ cpu_init[c]));
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign slot_trst_n[s] = !(!dbg_ovr_n || !cpu_rst_req_n[s*CPUS_PER_SLOT]);
   end

   a_r5_global_reaches_all: assert property (@(posedge clk) disable iff (!rst_n)
      glob_hrst |-> (cpu_hrst_n == '0));
   a_r7_bridge_reaches_all: assert property (@(posedge clk) disable iff (!rst_n)
      !bridge_srst_n |-> (cpu_srst_n == '0));
   a_r6_override_reaches_all: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_ovr_n |-> (slot_trst_n == '0));

endmodule

// File: rtl/smp_boot_status.sv
module smp_boot_status #(
   parameter int NUM_SLOTS     = 2,
   parameter int CPUS_PER_SLOT = 2
)(
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NUM_SLOTS*CPUS_PER_SLOT-1:0] halt_in,
   input  logic [NUM_SLOTS-1:0]               slot_cstop_n,
   output logic [NUM_SLOTS-1:0]               slot_halt,
   output logic                               all_halted,
   output logic                               cstop_out_n
);

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign slot_halt[s] = &halt_in[s*CPUS_PER_SLOT +: CPUS_PER_SLOT];
   end

   assign all_halted  = &halt_in;
   assign cstop_out_n = |slot_cstop_n;

   a_r8_all_implies_slots: assert property (@(posedge clk) disable iff (!rst_n)
      all_halted |-> (&slot_halt));
   a_r9_cstop_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
      !cstop_out_n |-> (slot_cstop_n == '0));

endmodule

// File: rtl/smp_boot_ctrl.sv
module smp_boot_ctrl #(
   parameter int NUM_SLOTS     = 2,
   parameter int CPUS_PER_SLOT = 2,
   parameter int ADDR_W        = 12,
   parameter int DATA_W        = 8,
   parameter int SEQ_W         = 2,
   parameter int HOLD_CYCLES   = 16,
   parameter logic [ADDR_W-1:0] ADDR_ARB    = 12'h81C,
   parameter logic [ADDR_W-1:0] ADDR_SEQ    = 12'h820,
   parameter logic [ADDR_W-1:0] ADDR_ENABLE = 12'h871
)(
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               hreset_in_n,
   input  logic                               bus_rd,
   input  logic                               bus_wr,
   input  logic [ADDR_W-1:0]                  bus_addr,
   input  logic [DATA_W-1:0]                  bus_wdata,
   output logic [DATA_W-1:0]                  bus_rdata,
   output logic                               sys_hrst_n,
   input  logic [NUM_SLOTS*CPUS_PER_SLOT-1:0] cpu_rst_req_n,
   input  logic                               dbg_ovr_n,
   input  logic                               bridge_srst_n,
   input  logic                               port92_rst,
   input  logic [NUM_SLOTS*CPUS_PER_SLOT-1:0] cpu_init,
   input  logic [NUM_SLOTS*CPUS_PER_SLOT-1:0] halt_in,
   input  logic [NUM_SLOTS-1:0]               slot_cstop_n,
   output logic [NUM_SLOTS*CPUS_PER_SLOT-1:0] cpu_hrst_n,
   output logic [NUM_SLOTS*CPUS_PER_SLOT-1:0] cpu_srst_n,
   output logic [NUM_SLOTS-1:0]               slot_trst_n,
   output logic [NUM_SLOTS-1:0]               slot_halt,
   output logic                               all_halted,
   output logic                               cstop_out_n
);

   if (NUM_SLOTS < 1 || CPUS_PER_SLOT < 1) begin : g_bad_shape
      $error("smp_boot_ctrl: need at least one slot and one processor per slot");
   end

   logic int_hrst;
   logic glob_hrst;
   logic enable_clear_wr;

   assign glob_hrst  = !hreset_in_n || int_hrst;
   assign sys_hrst_n = !glob_hrst;

   smp_boot_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W),
      .ADDR_ARB(ADDR_ARB), .ADDR_SEQ(ADDR_SEQ), .ADDR_ENABLE(ADDR_ENABLE)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .glob_hrst(glob_hrst),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .enable_clear_wr(enable_clear_wr)
   );

   smp_boot_hold #(
      .HOLD_CYCLES(HOLD_CYCLES)
   ) hold_i (
      .clk(clk), .rst_n(rst_n), .trigger(enable_clear_wr), .int_hrst(int_hrst)
   );

   smp_boot_fanout #(
      .NUM_SLOTS(NUM_SLOTS), .CPUS_PER_SLOT(CPUS_PER_SLOT)
   ) fanout_i (
      .clk(clk), .rst_n(rst_n), .glob_hrst(glob_hrst),
      .cpu_rst_req_n(cpu_rst_req_n), .dbg_ovr_n(dbg_ovr_n),
      .bridge_srst_n(bridge_srst_n), .port92_rst(port92_rst),
      .cpu_init(cpu_init), .cpu_hrst_n(cpu_hrst_n),
      .cpu_srst_n(cpu_srst_n), .slot_trst_n(slot_trst_n)
   );

   smp_boot_status #(
      .NUM_SLOTS(NUM_SLOTS), .CPUS_PER_SLOT(CPUS_PER_SLOT)
   ) status_i (
      .clk(clk), .rst_n(rst_n), .halt_in(halt_in), .slot_cstop_n(slot_cstop_n),
      .slot_halt(slot_halt), .all_halted(all_halted), .cstop_out_n(cstop_out_n)
   );

   a_r3_write_starts_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_clear_wr && !glob_hrst) |=> !sys_hrst_n);

endmodule

// File: tb/smp_boot_ctrl_tb.sv
module smp_boot_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;
   localparam logic [11:0] A_ARB = 12'h81C;
   localparam logic [11:0] A_SEQ = 12'h820;
   localparam logic [11:0] A_EN  = 12'h871;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hreset_in_n = 1'b1;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        sys_hrst_n;
   logic [3:0]  cpu_rst_req_n = 4'hF;
   logic        dbg_ovr_n = 1'b1, bridge_srst_n = 1'b1, port92_rst = 1'b0;
   logic [3:0]  cpu_init = '0, halt_in = '0;
   logic [1:0]  slot_cstop_n = 2'b11;
   logic [3:0]  cpu_hrst_n, cpu_srst_n;
   logic [1:0]  slot_trst_n, slot_halt;
   logic        all_halted, cstop_out_n;

   int n_checks = 0, n_fail = 0;
   bit done = 0;

   // reference model state
   bit   m_first = 0;
   int   m_seq = 0, m_hold = 0;
   int   m_rdata = 0;
   string m_tag = "R10";

   always #(CLK_PERIOD/2) clk = ~clk;

   smp_boot_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .hreset_in_n(hreset_in_n),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_hrst_n(sys_hrst_n),
      .cpu_rst_req_n(cpu_rst_req_n), .dbg_ovr_n(dbg_ovr_n),
      .bridge_srst_n(bridge_srst_n), .port92_rst(port92_rst),
      .cpu_init(cpu_init), .halt_in(halt_in), .slot_cstop_n(slot_cstop_n),
      .cpu_hrst_n(cpu_hrst_n), .cpu_srst_n(cpu_srst_n),
      .slot_trst_n(slot_trst_n), .slot_halt(slot_halt),
      .all_halted(all_halted), .cstop_out_n(cstop_out_n)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit m_glob();
      return !hreset_in_n || (m_hold != 0);
   endfunction

   // advance the model by one clock edge using the inputs applied before it
   task automatic model_edge();
      bit g = m_glob();
      bit trig = !g && bus_wr && bus_addr == A_EN && bus_wdata == 8'h00;
      if (m_hold != 0) m_hold--;
      else if (trig) m_hold = 16;
      if (g) begin
         m_first = 0; m_seq = 0; m_rdata = 0; m_tag = "R4";
      end else if (bus_rd) begin
         if (bus_addr == A_ARB) begin
            m_rdata = m_first ? 1 : 0; m_first = 1; m_tag = "R1";
         end else if (bus_addr == A_SEQ) begin
            m_rdata = m_seq; m_seq = (m_seq + 1) % 4; m_tag = "R2";
         end else begin
            m_rdata = 0; m_tag = "R10";
         end
      end else begin
         m_rdata = 0; m_tag = "R10";
      end
   endtask

   task automatic compare_all();
      bit g = m_glob();
      int e_h = 0, e_s = 0, e_t = 0, e_sh = 0;
      for (int i = 0; i < 4; i++) begin
         if (!(g || !cpu_rst_req_n[i])) e_h |= (1 << i);
         if (!(!bridge_srst_n || (port92_rst ^ cpu_init[i]))) e_s |= (1 << i);
      end
      for (int s = 0; s < 2; s++) begin
         if (!(!dbg_ovr_n || !cpu_rst_req_n[2*s])) e_t |= (1 << s);
         if (halt_in[2*s] && halt_in[2*s+1]) e_sh |= (1 << s);
      end
      check(m_tag, int'(bus_rdata), m_rdata);
      check("R3 sys_hrst_n", int'(sys_hrst_n), g ? 0 : 1);
      check("R5 cpu_hrst_n", int'(cpu_hrst_n), e_h);
      check("R7 cpu_srst_n", int'(cpu_srst_n), e_s);
      check("R6 slot_trst_n", int'(slot_trst_n), e_t);
      check("R8 slot_halt", int'(slot_halt), e_sh);
      check("R8 all_halted", int'(all_halted), (halt_in == 4'hF) ? 1 : 0);
      check("R9 cstop_out_n", int'(cstop_out_n), (slot_cstop_n == 2'b00) ? 0 : 1);
   endtask

   task automatic step();
      @(posedge clk);
      model_edge();
      #(CLK_PERIOD/4);
      compare_all();
   endtask

   task automatic bus_read(input logic [11:0] a);
      bus_rd = 1'b1; bus_addr = a;
      step();
      bus_rd = 1'b0;
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      step();
      bus_wr = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #(CLK_PERIOD/4);
      compare_all();                       // reset state
      rst_n = 1'b1;
      step();
      // R1: first read wins, later reads see 1
      bus_read(A_ARB);
      bus_read(A_ARB);
      bus_read(A_ARB);
      // R2: five reads reach the wrap 3 -> 0
      for (int k = 0; k < 5; k++) bus_read(A_SEQ);
      // R10: unmapped and enable-register reads return 0, no side effects
      bus_read(12'h123);
      bus_read(A_EN);
      bus_read(A_SEQ);
      // R3: nonzero write ignored
      bus_write(A_EN, 8'h55);
      step();
      // R3 / R4: zero write starts the 16-cycle hold; accesses ignored meanwhile
      bus_write(A_EN, 8'h00);
      for (int k = 0; k < 6; k++) bus_read(A_SEQ);
      bus_write(A_EN, 8'h00);
      for (int k = 0; k < 12; k++) step();
      bus_read(A_ARB);                      // R1 after reset: 0 again
      bus_read(A_SEQ);                      // R2 after reset: 0 again
      // R4: external hard reset clears state
      bus_read(A_SEQ);
      hreset_in_n = 1'b0;
      bus_read(A_ARB);
      step();
      hreset_in_n = 1'b1;
      bus_read(A_ARB);
      bus_read(A_SEQ);
      // R5-R9 sweep with mixed bus traffic
      for (int i = 0; i < 300; i++) begin
         logic [31:0] h = (i * 32'h9E3779B1) ^ (i << 11) ^ 32'h5A5A1234;
         cpu_rst_req_n = h[3:0] | h[7:4];
         cpu_init      = h[11:8];
         port92_rst    = h[12];
         bridge_srst_n = h[13] | h[14];
         dbg_ovr_n     = h[15] | h[16];
         halt_in       = h[20:17] | {4{h[21]}};
         slot_cstop_n  = h[23:22] & {2{h[24]}};
         hreset_in_n   = (h[27:25] != 3'd0);
         bus_rd        = h[28];
         bus_addr      = h[29] ? A_SEQ : A_ARB;
         bus_wr        = (i == 150);
         bus_wdata     = 8'h00;
         if (i == 150) bus_addr = A_EN;
         step();
      end
      bus_rd = 1'b0; bus_wr = 1'b0; hreset_in_n = 1'b1;
      for (int k = 0; k < 20; k++) step();
      finish_run();
   end

endmodule